// File: doc/BRIEF.md
# Multibank Row-Register DRAM Cache

This block is the front end of a paged DRAM store. A few full-row registers sit in front of a behavioural array that is organised as rows of bytes. Each access carries a row address, a column address, a read/write flag and, for writes, a data byte. The low bits of the row address pick one of the row registers (banks). The upper bits are the tag that the bank's own comparator checks. A dedicated hit output tells the controller in the request cycle whether that row is already held, so the controller needs no tag logic of its own.

A read hit returns the byte from the row register on the next cycle. A read miss raises busy for a parameterised number of fill cycles. It then copies the whole addressed row into the selected bank in one wide transfer and returns the requested byte. Writes always go to the array. When the row is cached, the register byte is updated as well, so the cache never holds stale data. A write miss does not claim a bank.

The default configuration is small: 16 rows of 16 bytes, four banks, three fill cycles. The full-size part uses `ROW_W=11` and `COL_W=8`, which gives 2048 rows of 256 bytes and a 9-bit tag per bank.

Top module: `rowbank_cache`

## Requirements
- R1: After a synchronous active-low reset, every bank is invalid and `busy`, `rvalid` and `hit` are low. The first request to any bank reports a miss.
- R2: The low `BANK_W` bits of `row` select the bank. The remaining upper bits form the tag compared in that bank, and the `col` field selects the byte within the row.
- R3: `hit` is high in the same cycle as an accepted request if the selected bank is valid and holds the requested tag. It reflects the state before any fill. At most one bank matches at a time.
- R4: A read hit raises `rvalid` for exactly one cycle, on the cycle after the request, with the addressed byte on `rdata`.
- R5: A read miss holds `busy` high for exactly `FILL_CYC` cycles, starting the cycle after the request. `rvalid` rises with the correct byte in the cycle `busy` falls. After that, every column of that row hits.
- R6: A fill replaces only the selected bank. Rows cached in the other banks keep hitting.
- R7: A write that hits updates both the array and the cached byte. A following read hits and returns the new value.
- R8: A write that misses updates the array and allocates no bank. A following read of that row misses and returns the written value.
- R9: A write completes in its request cycle. It raises neither `busy` nor `rvalid`.
- R10: A read miss to a row that shares a bank with a cached row evicts the older row. That older row then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, accepted when `busy` is low |
| we | input | 1 | 1 = write, 0 = read |
| row | input | ROW_W | Row address; low `BANK_W` bits pick the bank |
| col | input | COL_W | Column (byte) address within the row |
| wdata | input | DATA_W | Write data |
| hit | output | 1 | Request hits a cached row (combinational) |
| busy | output | 1 | Row fill in progress |
| rvalid | output | 1 | Read data valid pulse |
| rdata | output | DATA_W | Read data |

## Verification
The assertions assume that the controller raises `req` only while `busy` is low. A request during a fill would be dropped rather than queued, and the checks on hit and miss responses count only accepted requests. The bench follows this rule: every task waits until the previous access has finished, including the full fill window, before it drives the next strobe. It keeps its own model of bank tags and array bytes. It fills the whole array with an arithmetic pattern through write misses, then sweeps reads so that rows sharing a bank evict one another.

// File: rtl/rc_pkg.sv
// Shared definitions for the row-register cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rc_pkg;
    // Fill controller states
    typedef enum logic {
        FC_IDLE = 1'b0,
        FC_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/rc_fill_ctrl.sv
// Fill controller: on a start pulse holds busy for FILL_CYC cycles, and
// flags done in the last of them. Assumes FILL_CYC >= 1; start is ignored while busy.
module rc_fill_ctrl #(
    parameter int FILL_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    import rc_pkg::*;
    localparam int CW = $clog2(FILL_CYC + 1);

    fill_state_e   state;
    logic [CW-1:0] cnt;

    // Status decode
    assign busy = (state == FC_FILL);
    assign done = busy && (cnt == '0);

    // Count down the fill window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FC_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                FC_IDLE: if (start) begin
                    state <= FC_FILL;
                    cnt   <= CW'(FILL_CYC - 1);
                end
                FC_FILL: if (cnt == '0) state <= FC_IDLE;
                         else           cnt   <= cnt - 1'b1;
                default: state <= FC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rc_tag_cmp.sv
// Per-bank tag comparators. A bank matches only if it is the selected bank,
// it is valid, and its stored tag equals the request tag. Assumes BANKS == 2**BANK_W.
module rc_tag_cmp #(
    parameter int BANK_W = 2,
    parameter int TAG_W  = 2,
    localparam int BANKS = 1 << BANK_W
) (
    input  logic [BANK_W-1:0]            sel,
    input  logic [TAG_W-1:0]             tag_in,
    input  logic [BANKS-1:0][TAG_W-1:0]  tags,
    input  logic [BANKS-1:0]             valid,
    output logic [BANKS-1:0]             match
);
    for (genvar b = 0; b < BANKS; b++) begin : g_cmp
        // One comparator per bank
        assign match[b] = valid[b] && (sel == BANK_W'(b)) && (tags[b] == tag_in);
    end
endmodule

// File: rtl/rc_array.sv
// Behavioural paged DRAM array: one byte-write port and one full-row
// read port. Assumes contents are undefined until written; no reset.
module rc_array #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8,
    localparam int ROWS   = 1 << ROW_W,
    localparam int LINE_W = (1 << COL_W) * DATA_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [LINE_W-1:0] rd_line
);
    logic [LINE_W-1:0] mem [ROWS];

    // Byte write into the addressed row
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_row][DATA_W*int'(wr_col) +: DATA_W] <= wr_data;
    end

    // Wide row read for cache fills
    assign rd_line = mem[rd_row];
endmodule

// File: rtl/rowbank_cache.sv
// Multibank row-register cache in front of a paged array. Direct mapped:
// the low row bits pick the bank, the upper bits form the tag. Read misses
// fill a whole row; writes go through to the array and update a cached copy.
// Assumes req is raised only while busy is low (requests during a fill are dropped).
module rowbank_cache #(
    parameter int ROW_W    = 4,
    parameter int COL_W    = 4,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 2,
    parameter int FILL_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic              busy,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    localparam int BANKS  = 1 << BANK_W;
    localparam int TAG_W  = ROW_W - BANK_W;
    localparam int LINE_W = (1 << COL_W) * DATA_W;

    logic [LINE_W-1:0]           line_q [BANKS];
    logic [BANKS-1:0][TAG_W-1:0] tag_q;
    logic [BANKS-1:0]            valid_q;
    logic [BANKS-1:0]            bank_match;
    logic [ROW_W-1:0]            pend_row;
    logic [COL_W-1:0]            pend_col;
    logic [LINE_W-1:0]           fill_line;
    logic                        fill_done;

    logic [BANK_W-1:0] sel;
    logic [TAG_W-1:0]  rtag;
    logic [BANK_W-1:0] pbank;
    logic              accept, miss_start, write_go;

    // Request decode
    assign sel        = row[BANK_W-1:0];
    assign rtag       = row[ROW_W-1:BANK_W];
    assign pbank      = pend_row[BANK_W-1:0];
    assign accept     = req && !busy;
    assign hit        = accept && (|bank_match);
    assign miss_start = accept && !we && !(|bank_match);
    assign write_go   = accept && we;

    rc_tag_cmp #(.BANK_W(BANK_W), .TAG_W(TAG_W)) u_cmp (
        .sel    (sel),
        .tag_in (rtag),
        .tags   (tag_q),
        .valid  (valid_q),
        .match  (bank_match)
    );

    rc_fill_ctrl #(.FILL_CYC(FILL_CYC)) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .start (miss_start),
        .busy  (busy),
        .done  (fill_done)
    );

    rc_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .wr_en   (write_go),
        .wr_row  (row),
        .wr_col  (col),
        .wr_data (wdata),
        .rd_row  (pend_row),
        .rd_line (fill_line)
    );

    // Row register data: whole-row fill or write-hit byte update
    always_ff @(posedge clk) begin
        if (fill_done)
            line_q[pbank] <= fill_line;
        else if (write_go && hit)
            line_q[sel][DATA_W*int'(col) +: DATA_W] <= wdata;
    end

    // Tags, valid bits, pending address and read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            tag_q    <= '0;
            pend_row <= '0;
            pend_col <= '0;
            rvalid   <= 1'b0;
            rdata    <= '0;
        end else begin
            rvalid <= 1'b0;
            if (accept && !we && hit) begin
                rdata  <= line_q[sel][DATA_W*int'(col) +: DATA_W];
                rvalid <= 1'b1;
            end
            if (miss_start) begin
                pend_row <= row;
                pend_col <= col;
            end
            if (fill_done) begin
                tag_q[pbank]   <= pend_row[ROW_W-1:BANK_W];
                valid_q[pbank] <= 1'b1;
                rdata          <= fill_line[DATA_W*int'(pend_col) +: DATA_W];
                rvalid         <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rc_checker.sv
// Protocol checker for rowbank_cache, attached by bind. Assumes the
// controller issues requests only while busy is low.
module rc_checker #(
    parameter int BANKS    = 4,
    parameter int FILL_CYC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             we,
    input logic             hit,
    input logic             busy,
    input logic             rvalid,
    input logic [BANKS-1:0] bank_match
);
    logic [15:0] busy_len;

    // Length of the current busy window
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_len <= '0;
        else                 busy_len <= busy_len + 1'b1;
    end

    p_one_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_match));
    p_hit_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !busy);
    p_read_hit_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !busy && hit) |=> (rvalid && !busy));
    p_read_miss_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !busy && !hit) |=> (busy && !rvalid));
    p_fill_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == 16'(FILL_CYC) && rvalid));
    p_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && !busy) |=> (!busy && !rvalid));
endmodule

bind rowbank_cache rc_checker #(.BANKS(BANKS), .FILL_CYC(FILL_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .we         (we),
    .hit        (hit),
    .busy       (busy),
    .rvalid     (rvalid),
    .bank_match (bank_match)
);

// File: tb/rowbank_cache_test.sv
module rowbank_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int FILL = 3;
    localparam int NROW = 16;
    localparam int NCOL = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       we = 1'b0;
    logic [3:0] row = '0;
    logic [3:0] col = '0;
    logic [7:0] wdata = '0;
    logic       hit, busy, rvalid;
    logic [7:0] rdata;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    logic [7:0] mdl [NROW][NCOL];
    int  btag [4];
    bit  bval [4];

    rowbank_cache #(.ROW_W(4), .COL_W(4), .DATA_W(8), .BANK_W(2), .FILL_CYC(FILL)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .row(row), .col(col),
        .wdata(wdata), .hit(hit), .busy(busy), .rvalid(rvalid), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int r, input int c);
        return 8'((r * 37 + c * 11) ^ 8'hC3);
    endfunction

    function automatic bit cached(input int r);
        return bval[r % 4] && (btag[r % 4] == r / 4);
    endfunction

    // Read one byte; expected hit and data come from the bench model
    task automatic do_read(input int r, input int c, input string rq);
        bit eh;
        int n;
        eh = cached(r);
        req = 1'b1; we = 1'b0; row = 4'(r); col = 4'(c);
        #1 chk(hit === eh, {rq, "/R3 hit"}, int'(hit), int'(eh));
        @(negedge clk);
        req = 1'b0;
        if (eh) begin
            chk(rvalid === 1'b1 && busy === 1'b0, {rq, "/R4 rvalid"}, int'(rvalid), 1);
            chk(rdata === mdl[r][c], {rq, "/R4 data"}, int'(rdata), int'(mdl[r][c]));
        end else begin
            n = 0;
            while (busy === 1'b1 && n < 50) begin
                n++;
                @(negedge clk);
            end
            chk(n == FILL, {rq, "/R5 busy len"}, n, FILL);
            chk(rvalid === 1'b1, {rq, "/R5 rvalid"}, int'(rvalid), 1);
            chk(rdata === mdl[r][c], {rq, "/R5 data"}, int'(rdata), int'(mdl[r][c]));
            bval[r % 4] = 1'b1;
            btag[r % 4] = r / 4;
        end
        @(negedge clk);
        chk(rvalid === 1'b0, {rq, "/R4 single pulse"}, int'(rvalid), 0);
    endtask

    // Write one byte; no allocation in the model
    task automatic do_write(input int r, input int c, input logic [7:0] d, input string rq);
        bit eh;
        eh = cached(r);
        req = 1'b1; we = 1'b1; row = 4'(r); col = 4'(c); wdata = d;
        #1 chk(hit === eh, {rq, "/R3 hit"}, int'(hit), int'(eh));
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        chk(busy === 1'b0 && rvalid === 1'b0, "R9 write quiet", int'({busy, rvalid}), 0);
        mdl[r][c] = d;
    endtask

    initial begin
        for (int b = 0; b < 4; b++) begin bval[b] = 0; btag[b] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk(busy === 1'b0, "R1 busy", int'(busy), 0);
        chk(rvalid === 1'b0, "R1 rvalid", int'(rvalid), 0);
        chk(hit === 1'b0, "R1 hit", int'(hit), 0);

        // R8/R9: fill the array through write misses
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++)
                do_write(r, c, pat(r, c), "R8");

        // R1: first read misses; R5: then the whole row hits
        do_read(0, 3, "R1");
        for (int c = 0; c < NCOL; c++) do_read(0, c, "R5");

        // R6: load the other three banks, then all four still hit
        for (int r = 1; r < 4; r++) do_read(r, r * 2, "R6");
        for (int r = 0; r < 4; r++) do_read(r, 15 - r, "R6");

        // R2/R10: sweeps where rows in the same bank evict each other
        for (int p = 0; p < 3; p++)
            for (int r = 0; r < NROW; r++)
                do_read((r * 7 + p) % NROW, (r * 5 + p * 3) % NCOL, (p == 0) ? "R2" : "R10");
        do_read(1, 0, "R10");
        do_read(5, 0, "R10");
        do_read(1, 9, "R10");

        // R7: write hit updates the cached copy
        do_read(6, 2, "R7");
        do_write(6, 2, 8'h3C, "R7");
        do_read(6, 2, "R7");
        do_write(6, 15, 8'hE1, "R7");
        do_read(6, 15, "R7");

        // R8: write miss leaves the row uncached; read then fetches the new byte
        do_write(10, 4, 8'h77, "R8");
        do_read(10, 4, "R8");
        do_write(14, 0, 8'h00, "R8");
        do_read(14, 0, "R8");

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule